// File: doc/BRIEF.md
# Page-Splitting Chained DMA Engine

This block moves words between a streaming device port and a memory bus with no processor help per word. Software fills a small on-chip table of transfer descriptors through a register port, then writes a command that names the first descriptor. Each descriptor gives a physical byte address, a length in words, a direction, and the index of the descriptor that follows it. The engine walks the chain by itself. It stops when it reaches the end marker, when a length is zero, or when the memory fails to answer in time.

Memory is reached through a request/acknowledge bus that carries one word per acknowledged beat. The engine splits every descriptor into chunks that never cross a page boundary, and it issues each chunk as a burst whose final beat is flagged. The device side has two valid/ready streams, one toward memory and one away from it. A single level interrupt reports completion or failure and stays raised until software clears the cause. No address translation is performed.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset the status register reads zero (not busy, no done, no error, no overrun), `irq` is low and `mem_req` is low.
- R2: Register offsets are 0 command, 1 status, 2 timeout limit, 3 descriptor select, 4 descriptor address, 5 descriptor length and 6 descriptor control. A command write with bit 0 set while the engine is idle starts at the descriptor index held in bits [6:4]. In the status register, bit 0 is busy, bit 1 is done, bit 2 is error and bit 3 is overrun.
- R3: Descriptor fields are written at the entry chosen by the select register. The address is a word-aligned byte address, and the length counts 32-bit words. In the control field, bit 0 is the direction (1 reads memory and sends to the device, 0 takes device words and writes memory) and bits [6:4] hold the next index. A next index of 7 ends the chain.
- R4: Every chunk is min(remaining words, words left before the next 4096-byte page boundary). Each chunk is one burst, with `mem_last` high on its final beat, and no burst crosses a page.
- R5: Each acknowledged beat advances the address by 4 bytes and reduces the remaining count by one. Inside a burst, each beat's address is the previous beat's address plus 4.
- R6: While a request is not acknowledged, `mem_req` stays high and `mem_addr` stays unchanged, unless the engine aborts on a timeout.
- R7: In the device-to-memory direction, stream words are written to consecutive addresses in arrival order, with one word per acknowledged write.
- R8: In the memory-to-device direction, the words read are presented on the output stream in address order, and backpressure is honoured.
- R9: When a descriptor finishes with a next index other than 7, the named descriptor is loaded and run with no software action. Done is set only after the last descriptor.
- R10: If a request goes unacknowledged for the programmed number of consecutive cycles (a limit of zero turns the check off), the error bit is set, requests stop, the chain is abandoned and `irq` rises.
- R11: A descriptor whose length is zero sets the error bit without any memory request.
- R12: `irq` is high exactly while done or error is set. Writing 1 to status bit 1 or bit 2 clears that bit only.
- R13: A start command written while busy is ignored and sets the sticky overrun bit. Writing 1 to status bit 3 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_wdata | output | DATA_W | Write data |
| mem_last | output | 1 | Final beat of the current burst |
| mem_ack | input | 1 | Beat acknowledge |
| mem_rdata | input | DATA_W | Read data, valid with ack |
| dev_in_valid | input | 1 | Device-to-memory stream valid |
| dev_in_data | input | DATA_W | Device-to-memory stream data |
| dev_in_ready | output | 1 | Device-to-memory stream ready |
| dev_out_valid | output | 1 | Memory-to-device stream valid |
| dev_out_data | output | DATA_W | Memory-to-device stream data |
| dev_out_ready | input | 1 | Memory-to-device stream ready |
| irq | output | 1 | Level interrupt: done or error pending |

## Verification
The properties assume that the memory raises `mem_ack` only while `mem_req` is high and only for one cycle at a time. They also assume that the input stream keeps `dev_in_valid` and its data steady until the word is accepted, because the write request follows that valid. The bench's memory model acknowledges only a pending request, after a programmable delay or never, and drops the acknowledge right after the beat. Its device source holds each word until ready, and all descriptor addresses it programs are word aligned.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_CALC  = 3'd2,
    ST_BURST = 3'd3,
    ST_NEXT  = 3'd4,
    ST_DONE  = 3'd5,
    ST_ERR   = 3'd6
  } dma_state_e;

  localparam logic [2:0] OFS_CMD  = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_TMO  = 3'd2;
  localparam logic [2:0] OFS_DSEL = 3'd3;
  localparam logic [2:0] OFS_DADR = 3'd4;
  localparam logic [2:0] OFS_DLEN = 3'd5;
  localparam logic [2:0] OFS_DCTL = 3'd6;

  localparam int FLD_IDX_LSB = 4;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 16,
  parameter int NUM_DESC = 8,
  parameter int TMO_W    = 16,
  localparam int IDX_W   = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              set_done,
  input  logic              set_err,
  output logic              start,
  output logic [IDX_W-1:0]  start_idx,
  output logic [TMO_W-1:0]  tmo_lim,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LEN_W-1:0]  rd_len,
  output logic              rd_dir,
  output logic [IDX_W-1:0]  rd_next,
  output logic              irq
);

  logic [ADDR_W-1:0] tbl_addr [NUM_DESC];
  logic [LEN_W-1:0]  tbl_len  [NUM_DESC];
  logic              tbl_dir  [NUM_DESC];
  logic [IDX_W-1:0]  tbl_next [NUM_DESC];

  logic [IDX_W-1:0] sel_q;
  logic [TMO_W-1:0] tmo_q;
  logic done_q, err_q, ovr_q;
  logic done_n, err_n, ovr_n;
  logic wr_cmd, wr_stat, wr_tmo, wr_sel, go_bit;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata;

  assign wr_cmd  = reg_we && (reg_addr == OFS_CMD);
  assign wr_stat = reg_we && (reg_addr == OFS_STAT);
  assign wr_tmo  = reg_we && (reg_addr == OFS_TMO);
  assign wr_sel  = reg_we && (reg_addr == OFS_DSEL);
  assign go_bit  = wr_cmd && reg_wdata[0];

  assign start     = go_bit && !busy;
  assign start_idx = reg_wdata[FLD_IDX_LSB +: IDX_W];
  assign tmo_lim   = tmo_q;
  assign irq       = done_q | err_q;

  always_comb begin
    done_n = done_q;
    err_n  = err_q;
    ovr_n  = ovr_q;
    if (wr_stat) begin
      if (reg_wdata[1]) done_n = 1'b0;
      if (reg_wdata[2]) err_n  = 1'b0;
      if (reg_wdata[3]) ovr_n  = 1'b0;
    end
    if (set_done)      done_n = 1'b1;
    if (set_err)       err_n  = 1'b1;
    if (go_bit && busy) ovr_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      ovr_q  <= 1'b0;
      sel_q  <= '0;
      tmo_q  <= '0;
    end else begin
      done_q <= done_n;
      err_q  <= err_n;
      ovr_q  <= ovr_n;
      if (wr_sel) sel_q <= reg_wdata[IDX_W-1:0];
      if (wr_tmo) tmo_q <= reg_wdata[TMO_W-1:0];
    end
  end

  // descriptor storage: write-enabled, no reset
  for (genvar g = 0; g < NUM_DESC; g++) begin : g_entry
    logic hit;
    assign hit = reg_we && (sel_q == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (hit && reg_addr == OFS_DADR) tbl_addr[g] <= reg_wdata[ADDR_W-1:0];
      if (hit && reg_addr == OFS_DLEN) tbl_len[g]  <= reg_wdata[LEN_W-1:0];
      if (hit && reg_addr == OFS_DCTL) begin
        tbl_dir[g]  <= reg_wdata[0];
        tbl_next[g] <= reg_wdata[FLD_IDX_LSB +: IDX_W];
      end
    end
  end

  assign rd_addr = tbl_addr[rd_idx];
  assign rd_len  = tbl_len[rd_idx];
  assign rd_dir  = tbl_dir[rd_idx];
  assign rd_next = tbl_next[rd_idx];

  always_comb begin
    unique case (reg_addr)
      OFS_STAT: reg_rdata = {28'd0, ovr_q, err_q, done_q, busy};
      OFS_TMO:  reg_rdata = 32'(tmo_q);
      OFS_DSEL: reg_rdata = 32'(sel_q);
      OFS_DADR: reg_rdata = 32'(tbl_addr[sel_q]);
      OFS_DLEN: reg_rdata = 32'(tbl_len[sel_q]);
      OFS_DCTL: reg_rdata = 32'(tbl_next[sel_q]) << FLD_IDX_LSB | 32'(tbl_dir[sel_q]);
      default:  reg_rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/dma_chunk_calc.sv
module dma_chunk_calc #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 4096,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  remain,
  output logic [LEN_W-1:0]  chunk
);

  localparam int PG_SH      = $clog2(PAGE_BYTES);
  localparam int WB_SH      = $clog2(WORD_BYTES);
  localparam int PAGE_WORDS = PAGE_BYTES / WORD_BYTES;

  logic [PG_SH-WB_SH-1:0] ofs_words;
  logic [LEN_W:0]         room;
  logic                   unused_addr;

  assign unused_addr = ^{addr[ADDR_W-1:PG_SH], addr[WB_SH-1:0]};
  assign ofs_words   = addr[PG_SH-1:WB_SH];
  assign room        = (LEN_W+1)'(PAGE_WORDS) - (LEN_W+1)'(ofs_words);
  assign chunk       = ({1'b0, remain} < room) ? remain : room[LEN_W-1:0];

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int IDX_W      = 3,
  parameter int TMO_W      = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [TMO_W-1:0]  tmo_lim,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [LEN_W-1:0]  rd_len,
  input  logic              rd_dir,
  input  logic [IDX_W-1:0]  rd_next,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  cur_rem,
  input  logic [LEN_W-1:0]  chunk_in,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_last,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              dev_in_valid,
  input  logic [DATA_W-1:0] dev_in_data,
  output logic              dev_in_ready,
  output logic              dev_out_valid,
  output logic [DATA_W-1:0] dev_out_data,
  input  logic              dev_out_ready,
  output logic              busy,
  output logic              set_done,
  output logic              set_err
);

  localparam int WB_SH = $clog2(WORD_BYTES);
  localparam logic [IDX_W-1:0] IDX_END = '1;

  dma_state_e        state_q, state_n;
  logic [IDX_W-1:0]  idx_q, idx_n, nxt_q, nxt_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [LEN_W-1:0]  rem_q, rem_n, left_q, left_n;
  logic [TMO_W-1:0]  wait_q, wait_n;
  logic              dir_q, dir_n, hold_v_q, hold_v_n;
  logic [DATA_W-1:0] hold_d_q;
  logic              in_burst, have_beat, beat, hold_ld, tmo_hit;

  assign in_burst  = (state_q == ST_BURST);
  assign have_beat = (left_q != '0);
  assign mem_req   = in_burst && have_beat && (dir_q ? !hold_v_q : dev_in_valid);
  assign beat      = mem_req && mem_ack;
  assign hold_ld   = beat && dir_q;
  assign tmo_hit   = mem_req && !mem_ack && (tmo_lim != '0) &&
                     (wait_q == tmo_lim - 1'b1);

  assign mem_we        = !dir_q;
  assign mem_addr      = addr_q;
  assign mem_wdata     = dev_in_data;
  assign mem_last      = mem_req && (left_q == LEN_W'(1));
  assign dev_in_ready  = in_burst && !dir_q && have_beat && mem_ack;
  assign dev_out_valid = hold_v_q;
  assign dev_out_data  = hold_d_q;
  assign busy          = (state_q != ST_IDLE);
  assign set_done      = (state_q == ST_DONE);
  assign set_err       = (state_q == ST_ERR);
  assign rd_idx        = idx_q;
  assign cur_addr      = addr_q;
  assign cur_rem       = rem_q;

  always_comb begin
    state_n  = state_q;
    idx_n    = idx_q;
    nxt_n    = nxt_q;
    addr_n   = addr_q;
    rem_n    = rem_q;
    left_n   = left_q;
    wait_n   = wait_q;
    dir_n    = dir_q;
    hold_v_n = hold_v_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          idx_n   = start_idx;
          state_n = ST_LOAD;
        end
      end
      ST_LOAD: begin
        addr_n  = {rd_addr[ADDR_W-1:WB_SH], {WB_SH{1'b0}}};
        rem_n   = rd_len;
        dir_n   = rd_dir;
        nxt_n   = rd_next;
        state_n = (rd_len == '0) ? ST_ERR : ST_CALC;
      end
      ST_CALC: begin
        left_n  = chunk_in;
        wait_n  = '0;
        state_n = ST_BURST;
      end
      ST_BURST: begin
        if (beat) begin
          addr_n = addr_q + ADDR_W'(WORD_BYTES);
          rem_n  = rem_q - 1'b1;
          left_n = left_q - 1'b1;
          wait_n = '0;
          if (dir_q) hold_v_n = 1'b1;
        end else if (tmo_hit) begin
          state_n = ST_ERR;
        end else if (mem_req) begin
          wait_n = wait_q + 1'b1;
        end else begin
          wait_n = '0;
        end
        if (hold_v_q && dev_out_ready) hold_v_n = 1'b0;
        if (!have_beat && !hold_v_q) state_n = ST_NEXT;
      end
      ST_NEXT: begin
        if (rem_q != '0) begin
          state_n = ST_CALC;
        end else if (nxt_q == IDX_END) begin
          state_n = ST_DONE;
        end else begin
          idx_n   = nxt_q;
          state_n = ST_LOAD;
        end
      end
      ST_DONE: state_n = ST_IDLE;
      ST_ERR: begin
        hold_v_n = 1'b0;
        state_n  = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      nxt_q    <= '0;
      addr_q   <= '0;
      rem_q    <= '0;
      left_q   <= '0;
      wait_q   <= '0;
      dir_q    <= 1'b0;
      hold_v_q <= 1'b0;
    end else begin
      state_q  <= state_n;
      idx_q    <= idx_n;
      nxt_q    <= nxt_n;
      addr_q   <= addr_n;
      rem_q    <= rem_n;
      left_q   <= left_n;
      wait_q   <= wait_n;
      dir_q    <= dir_n;
      hold_v_q <= hold_v_n;
    end
  end

  always_ff @(posedge clk) begin
    if (hold_ld) hold_d_q <= mem_rdata;
  end

endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 4096,
  parameter int NUM_DESC   = 8,
  parameter int TMO_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_last,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              dev_in_valid,
  input  logic [DATA_W-1:0] dev_in_data,
  output logic              dev_in_ready,
  output logic              dev_out_valid,
  output logic [DATA_W-1:0] dev_out_data,
  input  logic              dev_out_ready,
  output logic              irq
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int IDX_W      = $clog2(NUM_DESC);

  logic              seq_busy, seq_done, seq_err, go;
  logic [IDX_W-1:0]  go_idx, tbl_idx, tbl_next;
  logic [TMO_W-1:0]  tmo_lim;
  logic [ADDR_W-1:0] tbl_addr, walk_addr;
  logic [LEN_W-1:0]  tbl_len, walk_rem, chunk;
  logic              tbl_dir;

  dma_regs #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .NUM_DESC(NUM_DESC), .TMO_W(TMO_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(seq_busy), .set_done(seq_done), .set_err(seq_err),
    .start(go), .start_idx(go_idx), .tmo_lim(tmo_lim),
    .rd_idx(tbl_idx), .rd_addr(tbl_addr), .rd_len(tbl_len),
    .rd_dir(tbl_dir), .rd_next(tbl_next), .irq(irq)
  );

  dma_chunk_calc #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .WORD_BYTES(WORD_BYTES)
  ) u_chunk (
    .addr(walk_addr), .remain(walk_rem), .chunk(chunk)
  );

  dma_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .IDX_W(IDX_W),
    .TMO_W(TMO_W), .WORD_BYTES(WORD_BYTES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(go), .start_idx(go_idx), .tmo_lim(tmo_lim),
    .rd_idx(tbl_idx), .rd_addr(tbl_addr), .rd_len(tbl_len),
    .rd_dir(tbl_dir), .rd_next(tbl_next),
    .cur_addr(walk_addr), .cur_rem(walk_rem), .chunk_in(chunk),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_last(mem_last), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
    .busy(seq_busy), .set_done(seq_done), .set_err(seq_err)
  );

endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int WORD_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_last,
  input logic              irq,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic              seq_err
);

  localparam int PG_SH = $clog2(PAGE_BYTES);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> (mem_req && $stable(mem_addr)) || seq_err); // R6

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_last |=> mem_addr == $past(mem_addr) + ADDR_W'(WORD_BYTES)); // R5

  AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_last |=>
      mem_addr[ADDR_W-1:PG_SH] == $past(mem_addr[ADDR_W-1:PG_SH])); // R4

  AST_ERR_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> irq); // R10

  AST_ERR_STOPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> !mem_req); // R10

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(reg_we && reg_addr == 3'd1) |=> irq); // R12

endmodule

bind dma_chain_engine dma_chain_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WORD_BYTES(DATA_W / 8)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_last(mem_last), .irq(irq),
  .reg_we(reg_we), .reg_addr(reg_addr), .seq_err(seq_err)
);

// File: tb/dma_chain_engine_test.sv
`timescale 1ns/1ps
module dma_chain_engine_test;

  logic        clk, rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_last, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        dev_in_valid, dev_in_ready, dev_out_valid, dev_out_ready;
  logic [31:0] dev_in_data, dev_out_data;
  logic        irq;

  int checks = 0;
  int failures = 0;

  // bench controls
  int ack_delay = 1;
  bit ack_block = 0;
  bit src_on = 0;
  bit sink_on = 0;
  bit sink_throttle = 0;

  dma_chain_engine uut (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_last(mem_last), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] pat(int w);
    return 32'h5A00_0000 | 32'(w);
  endfunction

  // memory model: 4096 words, unwritten words read as pat()
  logic [31:0] mem [0:4095];
  bit          wflag [0:4095];
  int          wcnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      wcnt      <= 0;
      for (int i = 0; i < 4096; i++) wflag[i] <= 1'b0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      wcnt    <= 0;
    end else if (mem_req && !ack_block) begin
      if (wcnt >= ack_delay) begin
        mem_ack   <= 1'b1;
        mem_rdata <= wflag[mem_addr[13:2]] ? mem[mem_addr[13:2]] : pat(int'(mem_addr[13:2]));
        if (mem_we) begin
          mem[mem_addr[13:2]]   <= mem_wdata;
          wflag[mem_addr[13:2]] <= 1'b1;
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end else begin
      wcnt <= 0;
    end
  end

  // beat log
  logic [31:0] blog_addr [0:255];
  bit          blog_last [0:255];
  int          nb;
  always @(posedge clk) begin
    if (!rst_n) nb <= 0;
    else if (mem_req && mem_ack) begin
      blog_addr[nb[7:0]] <= mem_addr;
      blog_last[nb[7:0]] <= mem_last;
      nb <= nb + 1;
    end
  end

  // device source and sink
  logic [31:0] src_word;
  logic [31:0] sink_log [0:255];
  int          ns;
  int          cyc;
  assign dev_in_valid  = src_on;
  assign dev_in_data   = src_word;
  assign dev_out_ready = sink_on && (!sink_throttle || cyc[0]);
  always @(posedge clk) begin
    if (!rst_n) begin
      src_word <= 32'hA000_0000;
      ns       <= 0;
      cyc      <= 0;
    end else begin
      cyc <= cyc + 1;
      if (dev_in_valid && dev_in_ready) src_word <= src_word + 1;
      if (dev_out_valid && dev_out_ready) begin
        sink_log[ns[7:0]] <= dev_out_data;
        ns <= ns + 1;
      end
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_desc(int idx, logic [31:0] a, int len, bit dir, int nxt);
    wr(3'd3, 32'(idx));
    wr(3'd4, a);
    wr(3'd5, 32'(len));
    wr(3'd6, (32'(nxt) << 4) | 32'(dir));
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(3'd1, s);
      if (!s[0]) return;
    end
    check(1'b0, "busy-timeout", 32'd1, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] s;
    rd(3'd1, s);
    check(s == 32'd0, "R1 status", s, 32'd0);
    check(irq == 1'b0, "R1 irq", 32'(irq), 32'd0);
    check(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 32'd0);
  endtask

  task automatic t_page_split();
    logic [31:0] s, base, rb;
    int b0;
    set_desc(0, 32'h0000_0FF0, 12, 1'b0, 7);
    rd(3'd6, rb);
    check(rb == 32'h70, "R3 control readback", rb, 32'h70);
    ack_delay = 1; src_on = 1;
    @(negedge clk);
    base = src_word; b0 = nb;
    wr(3'd0, 32'h0000_0001);
    wait_idle();
    src_on = 0;
    check(nb - b0 == 12, "R5 beat count", 32'(nb - b0), 32'd12);
    for (int i = 0; i < 12; i++) begin
      logic [31:0] ea;
      bit el;
      ea = 32'h0FF0 + 32'(4 * i);
      el = (i == 3) || (i == 11);
      check(blog_addr[b0 + i] == ea, "R5 beat address", blog_addr[b0 + i], ea);
      check(blog_last[b0 + i] == el, "R4 burst last", 32'(blog_last[b0 + i]), 32'(el));
      check(mem[ea[13:2]] == base + 32'(i), "R7 written word", mem[ea[13:2]], base + 32'(i));
    end
    rd(3'd1, s);
    check(s == 32'h2, "R2 status done", s, 32'h2);
    check(irq == 1'b1, "R12 irq on done", 32'(irq), 32'd1);
    wr(3'd1, 32'h2);
    rd(3'd1, s);
    check(s == 32'h0 && irq == 1'b0, "R12 clear done", s, 32'h0);
  endtask

  task automatic t_chain_read();
    logic [31:0] s;
    int b0, n0;
    logic [31:0] ea [0:7];
    bit          el [0:7];
    set_desc(2, 32'h0000_2000, 3, 1'b1, 3);
    set_desc(3, 32'h0000_2FF8, 5, 1'b1, 7);
    ea = '{32'h2000, 32'h2004, 32'h2008, 32'h2FF8, 32'h2FFC, 32'h3000, 32'h3004, 32'h3008};
    el = '{0, 0, 1, 0, 1, 0, 0, 1};
    ack_delay = 0; sink_on = 1; sink_throttle = 1;
    @(negedge clk);
    b0 = nb; n0 = ns;
    wr(3'd0, 32'h0000_0021);
    wait_idle();
    sink_on = 0; sink_throttle = 0;
    check(nb - b0 == 8, "R9 chained beats", 32'(nb - b0), 32'd8);
    check(ns - n0 == 8, "R8 words delivered", 32'(ns - n0), 32'd8);
    for (int i = 0; i < 8; i++) begin
      check(blog_addr[b0 + i] == ea[i], "R4 chain address", blog_addr[b0 + i], ea[i]);
      check(blog_last[b0 + i] == el[i], "R4 chain last", 32'(blog_last[b0 + i]), 32'(el[i]));
      check(sink_log[n0 + i] == pat(int'(ea[i][13:2])), "R8 stream order",
            sink_log[n0 + i], pat(int'(ea[i][13:2])));
    end
    rd(3'd1, s);
    check(s == 32'h2, "R9 done after end marker", s, 32'h2);
    wr(3'd1, 32'h2);
  endtask

  task automatic t_timeout();
    logic [31:0] s;
    int b0;
    set_desc(4, 32'h0000_0100, 4, 1'b0, 7);
    wr(3'd2, 32'd8);
    ack_delay = 2; src_on = 1;
    wr(3'd0, 32'h0000_0041);
    wait_idle();
    rd(3'd1, s);
    check(s == 32'h2, "R10 slow ack within limit", s, 32'h2);
    wr(3'd1, 32'h2);
    wr(3'd2, 32'd6);
    ack_block = 1;
    @(negedge clk);
    b0 = nb;
    wr(3'd0, 32'h0000_0041);
    wait_idle();
    src_on = 0;
    rd(3'd1, s);
    check(s == 32'h4, "R10 error on timeout", s, 32'h4);
    check(nb == b0, "R10 no beats", 32'(nb - b0), 32'd0);
    check(irq == 1'b1, "R10 irq", 32'(irq), 32'd1);
    check(mem_req == 1'b0, "R10 requests stop", 32'(mem_req), 32'd0);
    ack_block = 0;
    wr(3'd1, 32'h2);
    check(irq == 1'b1, "R12 done-clear keeps error", 32'(irq), 32'd1);
    wr(3'd1, 32'h4);
    rd(3'd1, s);
    check(s == 32'h0 && irq == 1'b0, "R12 error cleared", s, 32'h0);
  endtask

  task automatic t_zero_len();
    logic [31:0] s;
    int b0;
    set_desc(5, 32'h0000_0400, 0, 1'b0, 7);
    src_on = 1;
    @(negedge clk);
    b0 = nb;
    wr(3'd0, 32'h0000_0051);
    wait_idle();
    src_on = 0;
    rd(3'd1, s);
    check(s == 32'h4, "R11 zero length error", s, 32'h4);
    check(nb == b0, "R11 no request", 32'(nb - b0), 32'd0);
    wr(3'd1, 32'h4);
  endtask

  task automatic t_overrun();
    logic [31:0] s;
    int b0;
    set_desc(6, 32'h0000_0800, 8, 1'b0, 7);
    ack_delay = 4; src_on = 1;
    @(negedge clk);
    b0 = nb;
    wr(3'd0, 32'h0000_0061);
    wr(3'd0, 32'h0000_0051);
    wait_idle();
    src_on = 0;
    rd(3'd1, s);
    check(s == 32'hA, "R13 overrun with done", s, 32'hA);
    check(nb - b0 == 8, "R13 second start ignored", 32'(nb - b0), 32'd8);
    check(blog_addr[b0 + 7] == 32'h081C, "R13 last address", blog_addr[b0 + 7], 32'h081C);
    wr(3'd1, 32'h8);
    rd(3'd1, s);
    check(s == 32'h2, "R13 overrun cleared", s, 32'h2);
    wr(3'd1, 32'h2);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(100000 * 5);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_page_split();
    t_chain_read();
    t_timeout();
    t_zero_len();
    t_overrun();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule